// File: doc/BRIEF.md
# Dual-Channel GPIO Controller with Change Interrupt

This block is a general-purpose I/O peripheral behind a small register port. It has one or two channels of pins, and a parameter sets the width of both channels. Each channel has an output value register and a direction register. A direction bit of one makes that pin an input. A direction bit of zero makes it an output that drives the stored value onto the pin and asserts the pin's output enable. Input pins pass through a two-flop synchroniser. Reading the value register returns the synchronised level on input pins and the stored value on output pins.

Any change on an input pin of a channel sets that channel's bit in an interrupt status register. The status bit sets whether or not the channel is enabled. Software clears a status bit by writing a one back to it. A single interrupt line is raised when some channel has both its status bit and its enable bit set, and the master enable bit (bit 31 of its own register) is set.

The register port accepts a request whenever valid is high, because ready is always high. One cycle later it returns a response pulse, which carries the read data for a read.

Top module: `gpio_dual_ctrl`

## Requirements
- R1: Channel A's value register is at byte offset 0x000 and its direction register is at 0x004. pin_out_a equals the value register and pin_oe_a equals the inverse of the direction register.
- R2: After reset both direction registers are all ones, so every output enable is low, and both value registers are zero.
- R3: A read of a value register returns, for each bit, the input pin level from two clock edges before the read is accepted when the direction bit is 1, and the stored value when the direction bit is 0.
- R4: Channel B uses the same layout at 0x008 (value) and 0x00C (direction) and drives pin_out_b and pin_oe_b.
- R5: The status register at 0x120 sets bit 0 (channel A) or bit 1 (channel B) on the third clock edge after an input pin of that channel changes level. This happens even when that channel's enable bit is clear.
- R6: A write to 0x120 clears every status bit for which the written data has a one. A change detected in the same cycle keeps its bit set.
- R7: irq is high exactly when bit 31 of the master enable register at 0x11C is set and, for some channel, both the status bit and the enable bit (register 0x128, bit 0 for A and bit 1 for B) are set.
- R8: Reads of any offset other than 0x000, 0x004, 0x008, 0x00C, 0x11C, 0x120 and 0x128 return zero, and writes to them change no register or pin.
- R9: req_ready is always high. Every cycle with req_valid high is followed one cycle later by rsp_valid high, carrying the read data for a read and zero for a write. rsp_valid is low otherwise.
- R10: A level change on a pin whose direction bit is 0 does not set the channel's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| pin_in_a | input | CH_W | Channel A pin inputs |
| pin_out_a | output | CH_W | Channel A pin output values |
| pin_oe_a | output | CH_W | Channel A output enables |
| pin_in_b | input | CH_W | Channel B pin inputs |
| pin_out_b | output | CH_W | Channel B pin output values |
| pin_oe_b | output | CH_W | Channel B output enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bench drives req_valid, req_write, req_addr, req_wdata and the pin inputs as single-clock-domain signals that change only between clock edges. Synchroniser metastability is therefore not modelled. The checks also assume that register addresses are word aligned. The bench drives every input on the falling edge. Both its directed register accesses and its random traffic use aligned offsets only, taken from the seven mapped registers plus two unmapped ones. Pin patterns change at arbitrary cycles, so status set and clear can land in the same cycle without breaking any of these assumptions.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int unsigned OFF_VAL_A = 32'h000;
  localparam int unsigned OFF_DIR_A = 32'h004;
  localparam int unsigned OFF_VAL_B = 32'h008;
  localparam int unsigned OFF_DIR_B = 32'h00C;
  localparam int unsigned OFF_GIE   = 32'h11C;
  localparam int unsigned OFF_STS   = 32'h120;
  localparam int unsigned OFF_IEN   = 32'h128;

  // per-bit read view: synchronised input where dir=1, stored value where dir=0
  function automatic logic [31:0] pin_view(input logic [31:0] sync_in,
                                           input logic [31:0] stored,
                                           input logic [31:0] dir);
    return (sync_in & dir) | (stored & ~dir);
  endfunction

  function automatic logic irq_level(input logic gie, input logic [1:0] sts,
                                     input logic [1:0] ien);
    return gie & (|(sts & ien));
  endfunction

  function automatic logic is_mapped(input int unsigned off, input bit dual);
    case (off)
      OFF_VAL_A, OFF_DIR_A, OFF_GIE, OFF_STS, OFF_IEN: return 1'b1;
      OFF_VAL_B, OFF_DIR_B: return dual;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_dual_chan.sv
module gpio_dual_chan #(
  parameter int CH_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_val,
  input  logic            wr_dir,
  input  logic [CH_W-1:0] wdata,
  input  logic [CH_W-1:0] pin_in,
  output logic [CH_W-1:0] pin_out,
  output logic [CH_W-1:0] pin_oe,
  output logic [CH_W-1:0] rd_view,
  output logic            chg_evt
);
  import gpio_dual_pkg::*;

  logic [CH_W-1:0] val_q, dir_q, meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      dir_q  <= '1;
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      if (wr_val) val_q <= wdata;
      if (wr_dir) dir_q <= wdata;
      meta_q <= pin_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign pin_out = val_q;
  assign pin_oe  = ~dir_q;
  assign rd_view = CH_W'(pin_view(32'(sync_q), 32'(val_q), 32'(dir_q)));
  assign chg_evt = |((sync_q ^ last_q) & dir_q);
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chg_vec,
  input  logic           wr_gie,
  input  logic           wr_sts,
  input  logic           wr_ien,
  input  logic [31:0]    wdata,
  output logic           gie_q,
  output logic [NCH-1:0] sts_q,
  output logic [NCH-1:0] ien_q,
  output logic           irq
);
  import gpio_dual_pkg::*;

  logic [NCH-1:0] clr_mask;
  assign clr_mask = wr_sts ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_gie) gie_q <= wdata[31];
      if (wr_ien) ien_q <= wdata[NCH-1:0];
      sts_q <= (sts_q & ~clr_mask) | chg_vec;
    end
  end

  assign irq = irq_level(gie_q, 2'(sts_q), 2'(ien_q));
endmodule

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl #(
  parameter int CH_W   = 32,
  parameter bit DUAL   = 1'b1,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [CH_W-1:0]   pin_in_a,
  output logic [CH_W-1:0]   pin_out_a,
  output logic [CH_W-1:0]   pin_oe_a,
  input  logic [CH_W-1:0]   pin_in_b,
  output logic [CH_W-1:0]   pin_out_b,
  output logic [CH_W-1:0]   pin_oe_b,
  output logic              irq
);
  import gpio_dual_pkg::*;

  localparam int NCH = DUAL ? 2 : 1;

  int unsigned    off;
  logic           wr_en;
  logic           rd_en;
  logic [CH_W-1:0] view_a, view_b;
  logic [NCH-1:0] chg_vec;
  logic           gie_q;
  logic [NCH-1:0] sts_q, ien_q;
  logic [31:0]    rd_mux;

  assign off       = int'(req_addr);
  assign wr_en     = req_valid & req_write;
  assign rd_en     = req_valid & ~req_write;
  assign req_ready = 1'b1;

  gpio_dual_chan #(.CH_W(CH_W)) u_chan_a (
    .clk(clk), .rst_n(rst_n),
    .wr_val(wr_en && off == OFF_VAL_A), .wr_dir(wr_en && off == OFF_DIR_A),
    .wdata(req_wdata[CH_W-1:0]), .pin_in(pin_in_a),
    .pin_out(pin_out_a), .pin_oe(pin_oe_a), .rd_view(view_a), .chg_evt(chg_vec[0])
  );

  generate
    if (DUAL) begin : g_chan_b
      gpio_dual_chan #(.CH_W(CH_W)) u_chan_b (
        .clk(clk), .rst_n(rst_n),
        .wr_val(wr_en && off == OFF_VAL_B), .wr_dir(wr_en && off == OFF_DIR_B),
        .wdata(req_wdata[CH_W-1:0]), .pin_in(pin_in_b),
        .pin_out(pin_out_b), .pin_oe(pin_oe_b), .rd_view(view_b),
        .chg_evt(chg_vec[NCH-1])
      );
    end else begin : g_no_b
      assign pin_out_b = '0;
      assign pin_oe_b  = '0;
      assign view_b    = '0;
    end
  endgenerate

  gpio_dual_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .chg_vec(chg_vec),
    .wr_gie(wr_en && off == OFF_GIE), .wr_sts(wr_en && off == OFF_STS),
    .wr_ien(wr_en && off == OFF_IEN), .wdata(req_wdata),
    .gie_q(gie_q), .sts_q(sts_q), .ien_q(ien_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (off)
      OFF_VAL_A: rd_mux = 32'(view_a);
      OFF_DIR_A: rd_mux = 32'(~pin_oe_a);
      OFF_VAL_B: rd_mux = DUAL ? 32'(view_b) : '0;
      OFF_DIR_B: rd_mux = DUAL ? 32'(~pin_oe_b) : '0;
      OFF_GIE:   rd_mux = {gie_q, 31'b0};
      OFF_STS:   rd_mux = 32'(sts_q);
      OFF_IEN:   rd_mux = 32'(ien_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/gpio_dual_ctrl_chk.sv
module gpio_dual_ctrl_chk #(
  parameter int CH_W   = 32,
  parameter bit DUAL   = 1'b1,
  parameter int ADDR_W = 9,
  parameter int NCH    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wclr0,
  input logic              rsp_valid,
  input logic [CH_W-1:0]   pin_out_a,
  input logic [CH_W-1:0]   pin_oe_a,
  input logic              irq,
  input logic              gie_q,
  input logic [NCH-1:0]    chg_vec,
  input logic [NCH-1:0]    sts_q
);
  import gpio_dual_pkg::*;

  logic stray_wr;
  logic sts_clr0;
  assign stray_wr = req_valid && req_write && !is_mapped(int'(req_addr), DUAL);
  assign sts_clr0 = req_valid && req_write && int'(req_addr) == OFF_STS && wclr0;

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R5
  change_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_vec[0] |=> sts_q[0]);
  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr0 && !chg_vec[0]) |=> !sts_q[0]);
  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie_q);
  // R8
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> ($stable(pin_out_a) && $stable(pin_oe_a)));
  // R2
  reset_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe_a == '0 && pin_out_a == '0));
endmodule

bind gpio_dual_ctrl gpio_dual_ctrl_chk #(
  .CH_W(CH_W), .DUAL(DUAL), .ADDR_W(ADDR_W), .NCH(NCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .wclr0(req_wdata[0]), .rsp_valid(rsp_valid),
  .pin_out_a(pin_out_a), .pin_oe_a(pin_oe_a), .irq(irq), .gie_q(gie_q),
  .chg_vec(chg_vec), .sts_q(sts_q)
);

// File: tb/gpio_dual_ctrl_tb.sv
module gpio_dual_ctrl_tb;
  localparam int CH_W = 32;
  localparam int AW   = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, irq;
  logic [31:0]   rsp_rdata;
  logic [31:0]   pin_in_a = '0, pin_in_b = '0;
  logic [31:0]   pin_out_a, pin_oe_a, pin_out_b, pin_oe_b;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_dual_ctrl #(.CH_W(CH_W), .DUAL(1'b1), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pin_in_a(pin_in_a), .pin_out_a(pin_out_a), .pin_oe_a(pin_oe_a),
    .pin_in_b(pin_in_b), .pin_out_b(pin_out_b), .pin_oe_b(pin_oe_b), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_val [2];
  logic [31:0] m_dir [2];
  logic        m_gie;
  logic [1:0]  m_sts, m_ien;
  logic        m_rv;
  logic [31:0] m_rd;
  logic [31:0] hist_a [$];
  logic [31:0] hist_b [$];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    logic [1:0] seen;
    logic [1:0] next_sts;
    if (!rst_n) begin
      m_val = '{32'h0, 32'h0};
      m_dir = '{32'hFFFF_FFFF, 32'hFFFF_FFFF};
      m_gie = 1'b0; m_sts = 2'b00; m_ien = 2'b00;
      m_rv = 1'b0; m_rd = '0;
      hist_a = '{32'h0, 32'h0, 32'h0};
      hist_b = '{32'h0, 32'h0, 32'h0};
    end else begin
      seen[0] = ((hist_a[1] ^ hist_a[2]) & m_dir[0]) != 0;
      seen[1] = ((hist_b[1] ^ hist_b[2]) & m_dir[1]) != 0;
      m_rv = req_valid;
      m_rd = '0;
      if (req_valid && !req_write) begin
        case (int'(req_addr))
          'h000: m_rd = (hist_a[1] & m_dir[0]) | (m_val[0] & ~m_dir[0]);
          'h004: m_rd = m_dir[0];
          'h008: m_rd = (hist_b[1] & m_dir[1]) | (m_val[1] & ~m_dir[1]);
          'h00C: m_rd = m_dir[1];
          'h11C: m_rd = {m_gie, 31'b0};
          'h120: m_rd = {30'b0, m_sts};
          'h128: m_rd = {30'b0, m_ien};
          default: m_rd = '0;
        endcase
      end
      next_sts = m_sts;
      if (req_valid && req_write) begin
        case (int'(req_addr))
          'h000: m_val[0] = req_wdata;
          'h004: m_dir[0] = req_wdata;
          'h008: m_val[1] = req_wdata;
          'h00C: m_dir[1] = req_wdata;
          'h11C: m_gie = req_wdata[31];
          'h120: next_sts = next_sts & ~req_wdata[1:0];
          'h128: m_ien = req_wdata[1:0];
          default: ;
        endcase
      end
      m_sts = next_sts | seen;
      hist_a.push_front(pin_in_a); void'(hist_a.pop_back());
      hist_b.push_front(pin_in_b); void'(hist_b.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pin_out_a, m_val[0], "R1 pin_out_a");
      check(pin_oe_a, ~m_dir[0], "R1 pin_oe_a");
      check(pin_out_b, m_val[1], "R4 pin_out_b");
      check(pin_oe_b, ~m_dir[1], "R4 pin_oe_b");
      check(32'(irq), 32'(m_gie & (|(m_sts & m_ien))), "R7 irq");
      check(32'(rsp_valid), 32'(m_rv), "R9 rsp_valid");
      check(32'(req_ready), 32'h1, "R9 req_ready");
      check(rsp_rdata, m_rd, "R3 rsp_rdata");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int unsigned a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R2 reset state
    check(pin_oe_a, 32'h0, "R2 oe_a after reset");
    check(pin_out_b, 32'h0, "R2 out_b after reset");
    rd('h004, 32'hFFFF_FFFF, "R2 dir_a reset");
    rd('h00C, 32'hFFFF_FFFF, "R2 dir_b reset");
    rd('h000, 32'h0, "R2 val_a reset");
    // R1 outputs
    wr('h004, 32'hFFFF_0000);
    wr('h000, 32'h1234_ABCD);
    check(pin_out_a, 32'h1234_ABCD, "R1 out_a");
    check(pin_oe_a, 32'h0000_FFFF, "R1 oe_a");
    // R3 mixed read view
    pin_in_a = 32'hAAAA_5555;
    idle(4);
    rd('h000, 32'hAAAA_ABCD, "R3 mixed view");
    // R6 clear
    wr('h120, 32'h3);
    rd('h120, 32'h0, "R6 status cleared");
    // R5 + R7
    wr('h128, 32'h1);
    wr('h11C, 32'h8000_0000);
    check(32'(irq), 32'h0, "R7 idle irq");
    pin_in_a = 32'h2AAA_5555;
    idle(4);
    check(32'(irq), 32'h1, "R7 irq raised");
    rd('h120, 32'h1, "R5 status A set");
    wr('h120, 32'h1);
    check(32'(irq), 32'h0, "R6 irq dropped after clear");
    // R10 output pin toggle ignored
    pin_in_a = 32'h2AAA_5554;
    idle(4);
    rd('h120, 32'h0, "R10 output pin change ignored");
    // R4 channel B
    wr('h00C, 32'h0000_FF00);
    wr('h008, 32'h0000_5A5A);
    check(pin_out_b, 32'h0000_5A5A, "R4 out_b");
    check(pin_oe_b, 32'hFFFF_00FF, "R4 oe_b");
    pin_in_b = 32'h0000_3300;
    idle(4);
    rd('h008, 32'h0000_335A, "R4 view_b");
    rd('h120, 32'h2, "R5 status B set while disabled");
    check(32'(irq), 32'h0, "R7 B not enabled");
    wr('h128, 32'h3);
    check(32'(irq), 32'h1, "R7 B enabled");
    wr('h11C, 32'h7FFF_FFFF);
    check(32'(irq), 32'h0, "R7 master gate");
    rd('h11C, 32'h0, "R7 master reads back");
    // R8 unmapped
    wr('h010, 32'hDEAD_BEEF);
    wr('h124, 32'hFFFF_FFFF);
    rd('h010, 32'h0, "R8 unmapped read 0x010");
    rd('h124, 32'h0, "R8 unmapped read 0x124");
    check(pin_out_a, 32'h1234_ABCD, "R8 out_a untouched");
    rd('h004, 32'hFFFF_0000, "R8 dir_a untouched");
    // random traffic checked by the model every clock (R6 set/clear overlap)
    for (int i = 0; i < 3000; i++) begin
      int unsigned pick;
      @(negedge clk);
      pick = $urandom_range(0, 8);
      req_valid = ($urandom_range(0, 2) != 0);
      req_write = $urandom_range(0, 1) == 1;
      case (pick)
        0: req_addr = AW'('h000); 1: req_addr = AW'('h004);
        2: req_addr = AW'('h008); 3: req_addr = AW'('h00C);
        4: req_addr = AW'('h11C); 5: req_addr = AW'('h120);
        6: req_addr = AW'('h128); 7: req_addr = AW'('h014);
        default: req_addr = AW'('h12C);
      endcase
      req_wdata = $urandom();
      if ($urandom_range(0, 3) == 0) pin_in_a = pin_in_a ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) pin_in_b = pin_in_b ^ (32'h1 << $urandom_range(0, 31));
    end
    @(negedge clk);
    req_valid = 1'b0;
    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule